// File: doc/BRIEF.md
# Multifunction ALU with Barrel Shifter

A purely combinational arithmetic/logic unit for a datapath of parameterised width (32 bits by default). The block takes two operands and eight control bits. It returns one result word, a zero flag and a signed-overflow flag.

Inside, three units run side by side:

- an adder that can also subtract;
- a bitwise logic unit;
- a five-stage logarithmic shifter.

A two-bit class field picks which unit drives the result. A fourth class reports whether the difference of the operands is negative.

The control bits are split into fields:

| Field | Width |
|---|---|
| class | 2 |
| add/subtract | 1 |
| shift amount source | 1 |
| shift kind | 2 |
| logic function | 2 |

The shifter always shifts the second operand. Its amount comes either from a constant field supplied with the instruction, or from the low bits of the first operand.

Top module: `alu32`

## Requirements
- R1: `fn_class` selects the result source. 00 selects the shifter, 01 selects set-on-negative-difference, 10 selects the adder/subtractor and 11 selects the logic unit.
- R2: When `fn_class`=10, the result is `opnd_a + opnd_b` modulo 2^W if `arith_sub`=0, and `opnd_a - opnd_b` modulo 2^W if `arith_sub`=1.
- R3: When `fn_class`=10, `ovf` is 1 exactly when the signed add or subtract overflows. For an add this means both operands have the same sign and the result sign differs from it. For a subtract it means the operand signs differ and the result sign differs from the sign of `opnd_a`. `ovf` is 0 in every other class.
- R4: When `fn_class`=11, `logic_fn` selects the bitwise function: 00 = AND, 01 = OR, 10 = XOR, 11 = NOR.
- R5: When `fn_class`=00, `shift_kind` selects the shift applied to `opnd_b`: 01 = logical left, 10 = logical right, 11 = arithmetic right (the sign is copied in).
- R6: The shift amount is `opnd_a[4:0]` when `shift_var`=1 and `shamt_const` when `shift_var`=0. Bits of `opnd_a` above bit 4 have no effect on a shift.
- R7: When `fn_class`=01, bit 0 of the result is the sign bit of `opnd_a - opnd_b` (wrapped to W bits) and all other bits are 0. This holds whatever the value of `arith_sub`.
- R8: `zero` is 1 exactly when every bit of `result` is 0, in every class.
- R9: When `fn_class`=00 and `shift_kind`=00, the result equals `opnd_b` whatever the shift amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; its low 5 bits can be the shift amount |
| opnd_b | input | 32 | Second operand; this is the value that gets shifted |
| fn_class | input | 2 | Selects the unit that drives the result |
| arith_sub | input | 1 | 0 = add, 1 = subtract |
| shift_var | input | 1 | 1 = amount from `opnd_a`, 0 = amount from `shamt_const` |
| shift_kind | input | 2 | none / left / logical right / arithmetic right |
| logic_fn | input | 2 | AND / OR / XOR / NOR |
| shamt_const | input | 5 | Constant shift amount |
| result | output | 32 | Selected result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow in the arithmetic class |

## Verification
All three outputs are combinational, so each is due in the same cycle as the stimulus and no register sits on any path. The bench applies a new operand and control set, waits 1 ns so the logic settles, and samples `result`, `zero` and `ovf` before it changes any input again. Input changes fall after the falling clock edge, so every sample lies well clear of the rising edge. The bench sweeps all 256 control combinations against a grid of operand corner values, and compares each output with a value it computes from the requirements.

// File: rtl/alu32.sv
module alu32 #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [1:0]     fn_class,
  input  logic           arith_sub,
  input  logic           shift_var,
  input  logic [1:0]     shift_kind,
  input  logic [1:0]     logic_fn,
  input  logic [SHW-1:0] shamt_const,
  output logic [W-1:0]   result,
  output logic           zero,
  output logic           ovf
);
  localparam logic [1:0] C_SHIFT = 2'b00, C_SLT = 2'b01, C_ARITH = 2'b10, C_LOGIC = 2'b11;
  localparam logic [1:0] K_NONE = 2'b00, K_LEFT = 2'b01, K_ARITH = 2'b11;

  // adder / subtractor, forced to subtract for the negative-difference class
  logic do_sub;
  logic [W-1:0] b_eff, sum;
  assign do_sub = arith_sub | (fn_class == C_SLT);
  assign b_eff  = do_sub ? ~opnd_b : opnd_b;
  assign sum    = opnd_a + b_eff + W'(do_sub);

  // logic unit
  logic [W-1:0] lres;
  always_comb begin
    case (logic_fn)
      2'b00:   lres = opnd_a & opnd_b;
      2'b01:   lres = opnd_a | opnd_b;
      2'b10:   lres = opnd_a ^ opnd_b;
      default: lres = ~(opnd_a | opnd_b);
    endcase
  end

  // barrel shifter: stage i moves by 2**i or passes
  logic [SHW-1:0] amt;
  logic [W-1:0]   stg [0:SHW];
  assign amt    = (shift_kind == K_NONE) ? '0 : (shift_var ? opnd_a[SHW-1:0] : shamt_const);
  assign stg[0] = opnd_b;
  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stg[i+1] = !amt[i]                ? stg[i] :
                      (shift_kind == K_LEFT)  ? stg[i] << STEP :
                      (shift_kind == K_ARITH) ? W'($signed(stg[i]) >>> STEP) :
                                                stg[i] >> STEP;
  end

  always_comb begin
    case (fn_class)
      C_SHIFT: result = stg[SHW];
      C_SLT:   result = W'(sum[W-1]);
      C_ARITH: result = sum;
      default: result = lres;
    endcase
  end

  assign zero = ~|result;
  assign ovf  = (fn_class == C_ARITH) & (opnd_a[W-1] == b_eff[W-1]) & (sum[W-1] != opnd_a[W-1]);
endmodule

// File: rtl/alu32_props.sv
module alu32_props #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input logic [W-1:0]   opnd_a,
  input logic [W-1:0]   opnd_b,
  input logic [1:0]     fn_class,
  input logic           arith_sub,
  input logic           shift_var,
  input logic [1:0]     shift_kind,
  input logic [1:0]     logic_fn,
  input logic [SHW-1:0] shamt_const,
  input logic [W-1:0]   result,
  input logic           zero,
  input logic           ovf
);
  always_comb begin
    // R3
    ovf_class_chk: assert (fn_class == 2'b10 || !ovf) else $error("ovf outside arithmetic class");
    // R7
    slt_upper_chk: assert (fn_class != 2'b01 || result[W-1:1] == '0) else $error("slt upper bits set");
    // R9
    shift_pass_chk: assert (fn_class != 2'b00 || shift_kind != 2'b00 || result == opnd_b) else $error("no-shift altered operand");
    // R2
    add_zero_chk: assert (fn_class != 2'b10 || opnd_b != '0 || result == opnd_a) else $error("adding zero changed operand");
    // R8
    zero_flag_chk: assert (!zero || result == '0) else $error("zero flag with nonzero result");
    // R4
    and_self_chk: assert (fn_class != 2'b11 || logic_fn != 2'b00 || opnd_a != opnd_b || result == opnd_a) else $error("and of equal operands");
  end
endmodule

bind alu32 alu32_props #(.W(W), .SHW(SHW)) u_props (.*);

// File: tb/alu32_bench.sv
module alu32_bench;
  localparam int W = 32;
  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [1:0] cls, kind, lfn;
  logic sub, var_sel, zf, of;
  logic [4:0] sc;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  alu32 u_alu32 (.opnd_a(a), .opnd_b(b), .fn_class(cls), .arith_sub(sub), .shift_var(var_sel),
                 .shift_kind(kind), .logic_fn(lfn), .shamt_const(sc), .result(res), .zero(zf), .ovf(of));

  function automatic logic [W-1:0] pat(int k);
    case (k)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;  2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;  4: return 32'h7FFF_FFFF;  5: return 32'hA5A5_5A5A;
      6: return 32'h0000_001F;  7: return 32'hFFFF_FFE3;  8: return 32'h1234_5678;
      9: return 32'h8000_0001;  10: return 32'h0000_0010; default: return 32'hC000_0007;
    endcase
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h cls=%b sub=%b var=%b kind=%b lfn=%b sc=%0d)",
               tag, act, exp, a, b, cls, sub, var_sel, kind, lfn, sc);
    end
  endtask

  task automatic apply_and_check();
    logic [4:0] amt;
    logic [W-1:0] er, s;
    logic eo;
    #1;
    amt = var_sel ? a[4:0] : sc;
    s = sub ? a - b : a + b;
    eo = 0;
    case (cls)
      2'b00: case (kind)
               2'b00: er = b;
               2'b01: er = b << amt;
               2'b10: er = b >> amt;
               default: er = W'($signed(b) >>> amt);
             endcase
      2'b01: begin
        logic [W-1:0] d;
        d = a - b;
        er = {31'b0, d[W-1]};
      end
      2'b10: begin
        er = s;
        eo = sub ? (a[W-1] != b[W-1]) && (s[W-1] != a[W-1])
                 : (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
      end
      default: case (lfn)
                 2'b00: er = a & b;
                 2'b01: er = a | b;
                 2'b10: er = a ^ b;
                 default: er = ~(a | b);
               endcase
    endcase
    case (cls)
      2'b00: chk(kind == 2'b00 ? "R9 pass" : "R5/R6 shift", res, er);
      2'b01: chk("R7 slt", res, er);
      2'b10: chk("R2 arith", res, er);
      default: chk("R4 logic", res, er);
    endcase
    chk("R3 ovf", W'(of), W'(eo));
    chk("R8 zero", W'(zf), W'(er == 0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cls = 2'b10; sub = 0; var_sel = 0; kind = 0; lfn = 0; sc = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R8 idle state: zero operands add to zero
    #1; chk("R8 idle zero", W'(zf), 1); chk("R3 idle ovf", W'(of), 0); chk("R1 idle result", res, 0);
    // R6 upper operand-a bits ignored for the amount
    cls = 2'b00; kind = 2'b01; var_sel = 1; b = 32'h1; a = 32'hFFFF_FFE4;
    #1; chk("R6 amount low bits", res, 32'h10);
    // R9 no-shift with a large amount
    kind = 2'b00; sc = 5'd31; var_sel = 0; b = 32'hDEAD_BEEF;
    #1; chk("R9 no-shift", res, 32'hDEAD_BEEF);
    // R7 slt independent of arith_sub
    cls = 2'b01; sub = 0; a = 32'h1; b = 32'h2;
    #1; chk("R7 slt sub=0", res, 32'h1);
    for (int c = 0; c < 256; c++) begin
      for (int ia = 0; ia < 12; ia++) begin
        for (int ib = 0; ib < 12; ib++) begin
          @(negedge clk);
          {cls, sub, var_sel, kind, lfn} = 8'(c);
          a = pat(ia); b = pat(ib); sc = 5'((ia * 7 + ib * 3) % 32);
          apply_and_check();
        end
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule